// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This block sits between one processor and a shared, non-split snooping bus and keeps that processor's small object cache coherent with its peers. Every entry of a direct-mapped table holds an object tag, a data value and one of three states: Invalid, Read-only or Exclusive. The processor issues reads and writes through a request, busy and done handshake. The controller then either serves the request locally or sequences the bus messages it needs. It obtains the bus through a request and grant pair to an external arbiter.

All bus traffic is observed as well. A write request from another agent invalidates the matching entry. A read request makes any valid holder offer the value, and an Exclusive holder also drops to Read-only. A value response loads an Invalid entry at the object's slot. If another holder's response appears first, the pending response of this controller is cancelled. When a new object maps onto a slot held Exclusive, the displaced value is first written back as a value response, so memory and idle peers see it.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset cpu_busy_o, cpu_done_o and bus_req_o are low and every entry is Invalid, so the first read of any object goes to the bus.
- R2: A read of an object held Read-only or Exclusive completes with the local value and raises no bus request.
- R3: A read miss issues a read request (bus type 1) naming the object, waits for the value response (type 3) for that object, returns the carried value and leaves the entry Read-only.
- R4: A write to an object held Invalid or Read-only issues a write request (type 2) carrying the object and the new value, and leaves the entry Exclusive. A write to an Exclusive entry updates it with no bus traffic.
- R5: A snooped write request moves a matching Read-only or Exclusive entry to Invalid. An Invalid entry is not changed.
- R6: A snooped read request that hits a valid entry makes the controller request the bus and send a value response with that object and value. An Exclusive entry becomes Read-only.
- R7: A snooped value response loads an Invalid entry at the object's slot with the tag and value, in state Read-only.
- R8: A pending response is withdrawn (bus_req_o falls) when a value response for the same object is snooped before the grant.
- R9: A write that waits for the grant while a peer's write request to the same object is snooped still completes with its own write request and value, and ends Exclusive.
- R10: The slot is the low IDXW bits of the object id and the tag is the rest. A miss on a slot held Exclusive by another object first sends a value response with the old id and value, then the request.
- R11: A snooped message that reaches the pending operation's slot in the same cycle as a local completion takes precedence. The operation completes afterwards against the updated entry.
- R12: A request is accepted only while cpu_busy_o is low. cpu_busy_o stays high until completion, and cpu_done_o is a single-cycle pulse with cpu_rdata_o valid.

Message encoding on bus_type_o and snp_type_i: 0 none, 1 read request, 2 write request, 3 value response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request strobe |
| cpu_we_i | input | 1 | 1 write, 0 read |
| cpu_id_i | input | IDW | Object id |
| cpu_wdata_i | input | DW | Write value |
| cpu_busy_o | output | 1 | Operation in progress |
| cpu_done_o | output | 1 | Completion pulse |
| cpu_rdata_o | output | DW | Read result |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Grant; the message below is on the bus this cycle |
| bus_type_o | output | 2 | Outgoing message type |
| bus_id_o | output | IDW | Outgoing object id |
| bus_val_o | output | DW | Outgoing value |
| snp_vld_i | input | 1 | Message from another agent on the bus |
| snp_type_i | input | 2 | Snooped message type |
| snp_id_i | input | IDW | Snooped object id |
| snp_val_i | input | DW | Snooped value |

## Verification
The critical overlap is a snooped message landing on the slot of an operation that could finish locally in that same cycle. The bench holds an Exclusive entry, accepts a write to it, and drives a read request for that object in the first cycle the write is pending. It then expects the old value in a value response, followed by a write request with the new value. A lost arbitration is provoked the same way: the grant is withheld and a peer's write request is snooped. The final message and a later bus-free read must both show the controller's own value.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {CS_INV = 2'd0, CS_RO = 2'd1, CS_EX = 2'd2} cstate_e;
  typedef enum logic [1:0] {BM_NONE = 2'd0, BM_RD = 2'd1, BM_WR = 2'd2, BM_VR = 2'd3} bmsg_e;
  typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_ARB = 2'd1, FS_WAIT = 2'd2} fsm_e;
endpackage

// File: rtl/coh_store.sv
module coh_store import coh_pkg::*; #(
  parameter int NSET = 4,
  parameter int IXW  = 2,
  parameter int TAGW = 6,
  parameter int DW   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      a_en_i,
  input  logic [IXW-1:0]            a_idx_i,
  input  cstate_e                   a_st_i,
  input  logic [TAGW-1:0]           a_tag_i,
  input  logic [DW-1:0]             a_val_i,
  input  logic                      b_en_i,
  input  logic [IXW-1:0]            b_idx_i,
  input  cstate_e                   b_st_i,
  input  logic [TAGW-1:0]           b_tag_i,
  input  logic [DW-1:0]             b_val_i,
  output cstate_e [NSET-1:0]        st_o,
  output logic [NSET-1:0][TAGW-1:0] tag_o,
  output logic [NSET-1:0][DW-1:0]   val_o
);
  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_o[g]  <= CS_INV;
        tag_o[g] <= '0;
        val_o[g] <= '0;
      end else if (a_en_i && a_idx_i == IXW'(g)) begin
        st_o[g]  <= a_st_i;
        tag_o[g] <= a_tag_i;
        val_o[g] <= a_val_i;
      end else if (b_en_i && b_idx_i == IXW'(g)) begin
        st_o[g]  <= b_st_i;
        tag_o[g] <= b_tag_i;
        val_o[g] <= b_val_i;
      end
    end
  end
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop import coh_pkg::*; #(
  parameter int TAGW = 6,
  parameter int DW   = 16
) (
  input  logic            obs_i,
  input  bmsg_e           type_i,
  input  logic [TAGW-1:0] tag_i,
  input  logic [DW-1:0]   val_i,
  input  cstate_e         e_st_i,
  input  logic [TAGW-1:0] e_tag_i,
  input  logic [DW-1:0]   e_val_i,
  output logic            upd_en_o,
  output cstate_e         upd_st_o,
  output logic [TAGW-1:0] upd_tag_o,
  output logic [DW-1:0]   upd_val_o,
  output logic            rsp_set_o
);
  logic match;
  assign match = (e_st_i != CS_INV) && (e_tag_i == tag_i);

  always_comb begin
    upd_en_o  = 1'b0;
    upd_st_o  = e_st_i;
    upd_tag_o = e_tag_i;
    upd_val_o = e_val_i;
    rsp_set_o = 1'b0;
    if (obs_i) begin
      unique case (type_i)
        BM_WR: if (match) begin
          upd_en_o = 1'b1;
          upd_st_o = CS_INV;
        end
        BM_RD: if (match) begin
          rsp_set_o = 1'b1;
          if (e_st_i == CS_EX) begin
            upd_en_o = 1'b1;
            upd_st_o = CS_RO;
          end
        end
        BM_VR: if (e_st_i == CS_INV) begin
          upd_en_o  = 1'b1;
          upd_st_o  = CS_RO;
          upd_tag_o = tag_i;
          upd_val_o = val_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl import coh_pkg::*; #(
  parameter int IDW  = 8,
  parameter int DW   = 16,
  parameter int IDXW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cpu_req_i,
  input  logic            cpu_we_i,
  input  logic [IDW-1:0]  cpu_id_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  output logic            cpu_busy_o,
  output logic            cpu_done_o,
  output logic [DW-1:0]   cpu_rdata_o,
  output logic            bus_req_o,
  input  logic            bus_gnt_i,
  output logic [1:0]      bus_type_o,
  output logic [IDW-1:0]  bus_id_o,
  output logic [DW-1:0]   bus_val_o,
  input  logic            snp_vld_i,
  input  logic [1:0]      snp_type_i,
  input  logic [IDW-1:0]  snp_id_i,
  input  logic [DW-1:0]   snp_val_i
);
  localparam int NSET = 1 << IDXW;
  localparam int TAGW = IDW - IDXW;

  fsm_e                      fs_q;
  logic                      op_we_q;
  logic [IDW-1:0]            op_id_q;
  logic [DW-1:0]             op_wd_q;
  logic                      rsp_q;
  logic [IDXW-1:0]           rsp_idx_q;
  logic                      done_q;
  logic [DW-1:0]             rdata_q;

  cstate_e [NSET-1:0]        st;
  logic [NSET-1:0][TAGW-1:0] tg;
  logic [NSET-1:0][DW-1:0]   vl;

  logic [IDXW-1:0] op_idx, snp_idx;
  logic [TAGW-1:0] op_tag, snp_tag;
  bmsg_e           snp_type;
  assign op_idx   = op_id_q[IDXW-1:0];
  assign op_tag   = op_id_q[IDW-1:IDXW];
  assign snp_idx  = snp_id_i[IDXW-1:0];
  assign snp_tag  = snp_id_i[IDW-1:IDXW];
  assign snp_type = bmsg_e'(snp_type_i);

  logic snp_obs, snp_on_op, op_hit, loc_ok, need_wb, op_bus, grant, rsp_cancel;
  assign snp_obs   = snp_vld_i && !bus_gnt_i;
  assign snp_on_op = snp_obs && (snp_idx == op_idx);
  assign op_hit    = (st[op_idx] != CS_INV) && (tg[op_idx] == op_tag);
  assign loc_ok    = (fs_q == FS_ARB) && op_hit && (!op_we_q || st[op_idx] == CS_EX);
  assign need_wb   = (st[op_idx] == CS_EX) && !op_hit;
  assign op_bus    = (fs_q == FS_ARB) && !loc_ok;
  assign bus_req_o = rsp_q || op_bus;
  assign grant     = bus_gnt_i && bus_req_o;
  assign rsp_cancel = rsp_q && snp_obs && (snp_type == BM_VR) &&
                      (snp_idx == rsp_idx_q) && (snp_tag == tg[rsp_idx_q]);

  // outgoing message: pending response first, then write-back, then the op
  bmsg_e msg_t;
  always_comb begin
    msg_t     = BM_NONE;
    bus_id_o  = '0;
    bus_val_o = '0;
    if (rsp_q) begin
      msg_t     = BM_VR;
      bus_id_o  = {tg[rsp_idx_q], rsp_idx_q};
      bus_val_o = vl[rsp_idx_q];
    end else if (op_bus) begin
      if (need_wb) begin
        msg_t     = BM_VR;
        bus_id_o  = {tg[op_idx], op_idx};
        bus_val_o = vl[op_idx];
      end else if (op_we_q) begin
        msg_t     = BM_WR;
        bus_id_o  = op_id_q;
        bus_val_o = op_wd_q;
      end else begin
        msg_t     = BM_RD;
        bus_id_o  = op_id_q;
      end
    end
  end
  assign bus_type_o = msg_t;

  // snoop reaction on the slot addressed by the bus
  logic            a_en, rsp_set;
  cstate_e         a_st;
  logic [TAGW-1:0] a_tag;
  logic [DW-1:0]   a_val;

  coh_snoop #(.TAGW(TAGW), .DW(DW)) u_snoop (
    .obs_i     (snp_obs),
    .type_i    (snp_type),
    .tag_i     (snp_tag),
    .val_i     (snp_val_i),
    .e_st_i    (st[snp_idx]),
    .e_tag_i   (tg[snp_idx]),
    .e_val_i   (vl[snp_idx]),
    .upd_en_o  (a_en),
    .upd_st_o  (a_st),
    .upd_tag_o (a_tag),
    .upd_val_o (a_val),
    .rsp_set_o (rsp_set)
  );

  // own updates; never coincide with a snoop on the same slot
  logic            b_en;
  cstate_e         b_st;
  logic [TAGW-1:0] b_tag;
  logic [DW-1:0]   b_val;
  always_comb begin
    b_en  = 1'b0;
    b_st  = CS_INV;
    b_tag = tg[op_idx];
    b_val = vl[op_idx];
    if (grant && !rsp_q) begin
      b_en = 1'b1;
      if (!need_wb && op_we_q) begin
        b_st  = CS_EX;
        b_tag = op_tag;
        b_val = op_wd_q;
      end
    end else if (loc_ok && !snp_on_op && op_we_q) begin
      b_en  = 1'b1;
      b_st  = CS_EX;
      b_val = op_wd_q;
    end
  end

  coh_store #(.NSET(NSET), .IXW(IDXW), .TAGW(TAGW), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_en_i  (a_en),
    .a_idx_i (snp_idx),
    .a_st_i  (a_st),
    .a_tag_i (a_tag),
    .a_val_i (a_val),
    .b_en_i  (b_en),
    .b_idx_i (op_idx),
    .b_st_i  (b_st),
    .b_tag_i (b_tag),
    .b_val_i (b_val),
    .st_o    (st),
    .tag_o   (tg),
    .val_o   (vl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q      <= FS_IDLE;
      op_we_q   <= 1'b0;
      op_id_q   <= '0;
      op_wd_q   <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
      rsp_q     <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (fs_q)
        FS_IDLE: if (cpu_req_i) begin
          op_we_q <= cpu_we_i;
          op_id_q <= cpu_id_i;
          op_wd_q <= cpu_wdata_i;
          fs_q    <= FS_ARB;
        end
        FS_ARB: begin
          if (grant && !rsp_q) begin
            if (!need_wb) begin
              if (op_we_q) begin
                done_q  <= 1'b1;
                rdata_q <= op_wd_q;
                fs_q    <= FS_IDLE;
              end else begin
                fs_q <= FS_WAIT;
              end
            end
          end else if (loc_ok && !snp_on_op) begin
            done_q  <= 1'b1;
            rdata_q <= op_we_q ? op_wd_q : vl[op_idx];
            fs_q    <= FS_IDLE;
          end
        end
        FS_WAIT: if (snp_obs && snp_type == BM_VR && snp_id_i == op_id_q) begin
          done_q  <= 1'b1;
          rdata_q <= snp_val_i;
          fs_q    <= FS_IDLE;
        end
        default: fs_q <= FS_IDLE;
      endcase

      if (grant && rsp_q)  rsp_q <= 1'b0;
      else if (rsp_cancel) rsp_q <= 1'b0;
      if (rsp_set) begin
        rsp_q     <= 1'b1;
        rsp_idx_q <= snp_idx;
      end
    end
  end

  assign cpu_busy_o  = (fs_q != FS_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk import coh_pkg::*; #(
  parameter int IDW  = 8,
  parameter int IDXW = 2
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   cpu_busy_o,
  input logic                                   cpu_done_o,
  input logic                                   bus_req_o,
  input logic                                   bus_gnt_i,
  input logic [1:0]                             bus_type_o,
  input logic [IDW-1:0]                         bus_id_o,
  input logic                                   snp_vld_i,
  input logic [1:0]                             snp_type_i,
  input logic [IDW-1:0]                         snp_id_i,
  input cstate_e [(1<<IDXW)-1:0]                st,
  input logic [(1<<IDXW)-1:0][IDW-IDXW-1:0]     tg,
  input logic                                   rsp_q,
  input logic [IDXW-1:0]                        rsp_idx_q
);
  logic [IDXW-1:0]     sidx, bidx;
  logic [IDW-IDXW-1:0] stag;
  assign sidx = snp_id_i[IDXW-1:0];
  assign stag = snp_id_i[IDW-1:IDXW];
  assign bidx = bus_id_o[IDXW-1:0];

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !cpu_busy_o);

  assert_req_msg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_type_o != 2'd0);

  assert_wr_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_type_o == 2'd2) |=> st[$past(bidx)] == CS_EX);

  assert_snoop_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && !bus_gnt_i && snp_type_i == 2'd2 && st[sidx] != CS_INV && tg[sidx] == stag)
    |=> st[$past(sidx)] == CS_INV);

  assert_rsp_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_q && snp_vld_i && !bus_gnt_i && snp_type_i == 2'd3 &&
     sidx == rsp_idx_q && stag == tg[rsp_idx_q]) |=> !rsp_q);
endmodule

bind snoop_coh_ctrl coh_ctrl_chk #(.IDW(IDW), .IDXW(IDXW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_busy_o (cpu_busy_o),
  .cpu_done_o (cpu_done_o),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_type_o (bus_type_o),
  .bus_id_o   (bus_id_o),
  .snp_vld_i  (snp_vld_i),
  .snp_type_i (snp_type_i),
  .snp_id_i   (snp_id_i),
  .st         (st),
  .tg         (tg),
  .rsp_q      (rsp_q),
  .rsp_idx_q  (rsp_idx_q)
);

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
  import coh_pkg::*;
  localparam int IDW = 8, DW = 16, IDXW = 2, NSET = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [IDW-1:0] cpu_id = '0;
  logic [DW-1:0]  cpu_wd = '0;
  logic cpu_busy_o, cpu_done_o, bus_req_o;
  logic [DW-1:0] cpu_rdata_o, bus_val_o;
  logic gnt = 0;
  logic [1:0] bus_type_o;
  logic [IDW-1:0] bus_id_o;
  logic snp_vld = 0;
  logic [1:0] snp_type = '0;
  logic [IDW-1:0] snp_id = '0;
  logic [DW-1:0] snp_val = '0;

  snoop_coh_ctrl #(.IDW(IDW), .DW(DW), .IDXW(IDXW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_id_i(cpu_id), .cpu_wdata_i(cpu_wd),
    .cpu_busy_o(cpu_busy_o), .cpu_done_o(cpu_done_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(gnt), .bus_type_o(bus_type_o),
    .bus_id_o(bus_id_o), .bus_val_o(bus_val_o),
    .snp_vld_i(snp_vld), .snp_type_i(snp_type), .snp_id_i(snp_id), .snp_val_i(snp_val));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] truth [8];
  cstate_e m_st [NSET];
  logic [IDW-1:0] m_id [NSET];
  logic [DW-1:0] m_val [NSET];
  int q_n;
  logic [1:0] q_t [4];
  logic [IDW-1:0] q_id [4];
  logic [DW-1:0] q_v [4];

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] t, input logic [IDW-1:0] id, input logic [DW-1:0] v);
    q_t[q_n] = t; q_id[q_n] = id; q_v[q_n] = v; q_n++;
  endtask

  function automatic bit m_hit(input logic [IDW-1:0] id);
    return m_st[id[1:0]] != CS_INV && m_id[id[1:0]] == id;
  endfunction

  // expected bus messages of a plain op, from the model
  task automatic plan_op(input bit we, input logic [IDW-1:0] id, input logic [DW-1:0] wd);
    int ix = int'(id[1:0]);
    q_n = 0;
    if (m_hit(id) && (!we || m_st[ix] == CS_EX)) return;
    if (m_st[ix] == CS_EX && !m_hit(id)) push(2'd3, m_id[ix], m_val[ix]);
    if (we) push(2'd2, id, wd); else push(2'd1, id, '0);
  endtask

  task automatic model_op(input bit we, input logic [IDW-1:0] id, input logic [DW-1:0] wd);
    int ix = int'(id[1:0]);
    if (we) begin
      m_st[ix] = CS_EX; m_id[ix] = id; m_val[ix] = wd; truth[id[2:0]] = wd;
    end else if (!m_hit(id)) begin
      m_st[ix] = CS_RO; m_id[ix] = id; m_val[ix] = truth[id[2:0]];
    end
  endtask

  task automatic cpu_op(input bit we, input logic [IDW-1:0] id, input logic [DW-1:0] wd,
                        input logic [1:0] inj_t, input logic [IDW-1:0] inj_id,
                        input logic [DW-1:0] inj_v, input string rq,
                        output logic [DW-1:0] rd);
    int k = 0;
    bit fin = 0;
    rd = '0;
    @(negedge clk);
    chk(rq, "busy before request", cpu_busy_o, 0);
    cpu_req = 1; cpu_we = we; cpu_id = id; cpu_wd = wd;
    @(negedge clk);
    cpu_req = 0;
    chk(rq, "busy after accept", cpu_busy_o, 1);
    if (inj_t != 2'd0) begin
      snp_vld = 1; snp_type = inj_t; snp_id = inj_id; snp_val = inj_v;
      @(negedge clk);
      snp_vld = 0;
    end
    for (int c = 0; c < 40 && !fin; c++) begin
      if (cpu_done_o) begin
        fin = 1; rd = cpu_rdata_o;
        chk(rq, "busy at done", cpu_busy_o, 0);
      end else if (bus_req_o) begin
        bit is_rd = (bus_type_o == 2'd1);
        if (k < q_n) begin
          chk(rq, "msg type", bus_type_o, q_t[k]);
          chk(rq, "msg id", bus_id_o, q_id[k]);
          if (!is_rd) chk(rq, "msg value", bus_val_o, q_v[k]);
        end else chk(rq, "unexpected bus request", 1, 0);
        k++;
        gnt = 1;
        @(negedge clk);
        gnt = 0;
        if (is_rd) begin
          snp_vld = 1; snp_type = 2'd3; snp_id = id; snp_val = truth[id[2:0]];
          @(negedge clk);
          snp_vld = 0;
        end
      end else @(negedge clk);
    end
    chk(rq, "op completed", fin, 1);
    chk(rq, "message count", k, q_n);
  endtask

  task automatic run_op(input bit we, input logic [IDW-1:0] id, input logic [DW-1:0] wd,
                        input string rq);
    logic [DW-1:0] rd;
    plan_op(we, id, wd);
    cpu_op(we, id, wd, 2'd0, '0, '0, rq, rd);
    model_op(we, id, wd);
    if (!we) chk(rq, "read value", rd, truth[id[2:0]]);
  endtask

  task automatic snoop(input logic [1:0] t, input logic [IDW-1:0] id, input logic [DW-1:0] v,
                       input string rq);
    int ix = int'(id[1:0]);
    bit hit = m_hit(id);
    bit exp_rsp = (t == 2'd1) && hit;
    @(negedge clk);
    snp_vld = 1; snp_type = t; snp_id = id; snp_val = v;
    @(negedge clk);
    snp_vld = 0;
    chk(rq, "response request", bus_req_o, exp_rsp);
    if (bus_req_o) begin
      chk(rq, "response type", bus_type_o, 2'd3);
      chk(rq, "response id", bus_id_o, id);
      chk(rq, "response value", bus_val_o, truth[id[2:0]]);
      gnt = 1;
      @(negedge clk);
      gnt = 0;
    end
    chk(rq, "bus idle after snoop", bus_req_o, 0);
    case (t)
      2'd2: begin if (hit) m_st[ix] = CS_INV; truth[id[2:0]] = v; end
      2'd1: if (hit && m_st[ix] == CS_EX) m_st[ix] = CS_RO;
      2'd3: if (m_st[ix] == CS_INV) begin m_st[ix] = CS_RO; m_id[ix] = id; m_val[ix] = v; end
      default: ;
    endcase
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) truth[i] = DW'(16'h100 + i);
    for (int i = 0; i < NSET; i++) begin m_st[i] = CS_INV; m_id[i] = '0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", cpu_busy_o, 0);
    chk("R1", "done in reset", cpu_done_o, 0);
    chk("R1", "bus_req in reset", bus_req_o, 0);
    rst_n = 1;

    run_op(0, 8'd1, '0, "R1 R3 first read misses");
    run_op(0, 8'd1, '0, "R2 read hit");
    snoop(2'd1, 8'd1, '0, "R6 read-only holder answers");

    // R8: response withdrawn on a competing value response
    @(negedge clk);
    snp_vld = 1; snp_type = 2'd1; snp_id = 8'd1;
    @(negedge clk);
    chk("R8", "pending response", bus_req_o, 1);
    snp_type = 2'd3; snp_val = truth[1];
    @(negedge clk);
    snp_vld = 0;
    chk("R8", "response withdrawn", bus_req_o, 0);

    run_op(1, 8'd1, 16'hA001, "R4 write from read-only");
    run_op(1, 8'd1, 16'hA002, "R4 write in exclusive is local");
    snoop(2'd1, 8'd1, '0, "R6 exclusive holder answers");
    run_op(1, 8'd1, 16'hA003, "R6 exclusive dropped to read-only");
    snoop(2'd1, 8'd1, '0, "R6 back to read-only");

    // R9: peer write wins first, own write still completes
    q_n = 0; push(2'd2, 8'd1, 16'hB009);
    cpu_op(1, 8'd1, 16'hB009, 2'd2, 8'd1, 16'hEEEE, "R9 lost arbitration", rd);
    model_op(1, 8'd1, 16'hB009);
    run_op(0, 8'd1, '0, "R9 own value kept exclusive");

    // R11: snoop read lands with a local exclusive write
    q_n = 0; push(2'd3, 8'd1, 16'hB009); push(2'd2, 8'd1, 16'hC011);
    cpu_op(1, 8'd1, 16'hC011, 2'd1, 8'd1, '0, "R11 snoop precedence", rd);
    model_op(1, 8'd1, 16'hC011);
    run_op(0, 8'd1, '0, "R11 final value");

    run_op(1, 8'd5, 16'hD005, "R10 write-back then write");
    run_op(0, 8'd1, '0, "R10 displaced value refetched");

    snoop(2'd3, 8'd2, truth[2], "R7 capture into invalid");
    run_op(0, 8'd2, '0, "R7 captured entry hits");
    snoop(2'd2, 8'd2, 16'h7777, "R5 invalidate read-only");
    run_op(0, 8'd2, '0, "R5 refetch after invalidate");
    snoop(2'd2, 8'd3, 16'h3333, "R5 invalid entry unchanged");
    run_op(0, 8'd3, '0, "R5 read after ignored invalidate");

    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 9));
      logic [IDW-1:0] id = IDW'($urandom_range(0, 7));
      logic [DW-1:0] v = DW'($urandom);
      if (sel < 3) run_op(0, id, '0, "R2 R3 random read");
      else if (sel < 6) run_op(1, id, v, "R4 R10 random write");
      else if (sel < 8) snoop(2'd1, id, '0, "R6 random snoop read");
      else if (sel < 9) snoop(2'd2, id, v, "R5 random snoop write");
      else if (!m_hit(id)) snoop(2'd3, id, truth[id[2:0]], "R7 random value response");
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule